// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer Channel

One timer channel built around a 32-bit down counter. A 2-bit mode input selects one of four behaviours:
- free-running periodic countdown;
- a split countdown, where the low half runs first and the high half then sets the length of a long pre-trigger window;
- an event accumulator that steps once per trigger edge;
- an interval capture that stores the number of elapsed clocks when a trigger edge arrives.

At timeout the channel raises a sticky interrupt flag that is cleared by writing one. It also drives a pre-trigger output and a trigger output that lags it by one clock.

Control bits set how the channel starts, stops and reloads:
- start-on-trigger makes the channel wait for a trigger edge instead of the enable rising edge;
- stop-on-interrupt halts the counter after a timeout;
- reload-on-trigger restarts a running periodic count from the load value.

A source-select bit picks whether the trigger comes from an internal input or an external input. All pins are plain control and status. No data stream crosses the block edge, so there is no handshake or back-pressure.

Top module: `tmr_channel`

## Requirements
- R1: Mode 0 (periodic): the enable rising edge loads the load value N. The count then drops by one per clock. The step taken at zero is a timeout, which sets the flag and reloads N, so timeouts come every N+1 clocks.
- R2: Mode 1 (split): the low 16 bits count down first. Each step with low half zero and high half H nonzero decrements the high half and holds the pre-trigger window open. The step at full zero closes the window and is the timeout.
- R3: Mode 2 (accumulator): after start the count is static. The first trigger edge loads the load value. Each later trigger edge decrements the count. An edge that arrives at zero is the timeout and reloads.
- R4: Mode 3 (capture): the count starts at all ones and decrements each clock, wrapping from zero back to all ones with no flag. A trigger edge writes the bitwise inverse of the count into the load-value register, sets the flag, fires the pulses and restarts the count at all ones. The capture write takes priority over a software load write on the same clock.
- R5: The trigger output rises exactly one clock after the pre-trigger output rises. It is never high while pre-trigger is low.
- R6: Outside mode 1, one event gives two clocks of pre-trigger and one clock of trigger. In mode 1, pre-trigger is high for H clocks and trigger for H-1 clocks, and both fall on the timeout clock.
- R7: With stop-on-interrupt set, the counter freezes after a timeout. It restarts with a reload only on a trigger edge (start-on-trigger set) or on an enable rising edge (start-on-trigger clear).
- R8: The interrupt flag stays set until a clear pulse. A clear on the same clock as a new timeout leaves it set.
- R9: With start-on-trigger set, an enabled channel stays idle until a trigger edge. With reload-on-trigger set, a trigger edge during a mode 0 or mode 1 count reloads the load value.
- R10: Source select 0 uses the internal trigger input and 1 uses the external one. The unselected input has no effect.
- R11: Enable low stops counting and holds the count. Pre-trigger and trigger go low on the next clock, and the load-value register keeps its contents.
- R12: The trigger takes effect on the second clock edge after it goes high. Only a 0-to-1 change counts, so a held level acts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Mode: 0 periodic, 1 split, 2 accumulator, 3 capture |
| start_on_trig_i | input | 1 | Start or restart on trigger edge instead of enable edge |
| stop_on_irq_i | input | 1 | Halt after timeout |
| reload_on_trig_i | input | 1 | Trigger edge reloads a running periodic count |
| trig_src_i | input | 1 | Trigger select: 0 internal, 1 external |
| trig_int_i | input | 1 | Internal trigger input |
| trig_ext_i | input | 1 | External trigger input |
| ld_we_i | input | 1 | Load-value write strobe |
| ld_wdata_i | input | 32 | Load-value write data |
| irq_clr_i | input | 1 | Write-one-to-clear for the flag |
| ld_val_o | output | 32 | Load-value register |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | Sticky interrupt flag |
| pre_trig_o | output | 1 | Pre-trigger output |
| trig_o | output | 1 | Trigger output |

## Verification
The periodic count runs with a small load value so that the timeout clock, the reload and the two pulse clocks can all be pinned exactly. The split mode uses unequal halves, so a window governed by the wrong half shows up as a wrong length. The accumulator is run without triggers and then with separated pulses; this separates clock-driven stepping from edge-driven stepping and shows the deferred first load. Capture after a known number of clocks checks the inversion. Held trigger levels, toggling of the unselected input, and a clear that coincides with a timeout probe edge detection, source selection and flag priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TM_PER32  = 2'd0,
    TM_DUAL16 = 2'd1,
    TM_ACCUM  = 2'd2,
    TM_CAPT   = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic int_i,
  input  logic ext_i,
  output logic edge_o
);
  logic              sel;
  logic [STAGES-1:0] sq;
  logic              prev_q;

  assign sel = src_i ? ext_i : int_i;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '0;
        else         sq <= sel;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '0;
        else         sq <= {sq[STAGES-2:0], sel};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sq[STAGES-1];
  end

  // registered level compared with its own delayed copy
  assign edge_o = sq[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             start_on_trig_i,
  input  logic             stop_on_irq_i,
  input  logic             reload_on_trig_i,
  input  logic             trig_edge_i,
  input  logic             ld_we_i,
  input  logic [CNT_W-1:0] ld_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic             tmo_o,
  output logic             fire_o,
  output logic             win_o
);
  localparam int HALF = CNT_W / 2;

  tmr_mode_e        mode;
  logic             en_q, run_q, primed_q;
  logic             run_d, primed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, ld_q, ld_d, load_val;
  logic [HALF-1:0]  lo, hi;
  logic             en_rise, start_req, tmo, cap, win;

  assign mode      = tmr_mode_e'(mode_i);
  assign lo        = cnt_q[HALF-1:0];
  assign hi        = cnt_q[CNT_W-1:HALF];
  assign en_rise   = en_i & ~en_q;
  assign start_req = start_on_trig_i ? trig_edge_i : en_rise;
  assign load_val  = (mode == TM_CAPT) ? '1 : ld_q;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    primed_d = primed_q;
    tmo      = 1'b0;
    cap      = 1'b0;
    win      = 1'b0;
    if (!en_i) begin
      run_d = 1'b0;
    end else if (!run_q) begin
      if (start_req) begin
        run_d    = 1'b1;
        cnt_d    = load_val;
        primed_d = (mode != TM_ACCUM) || start_on_trig_i;
      end
    end else begin
      case (mode)
        TM_PER32: begin
          if (reload_on_trig_i && trig_edge_i) cnt_d = load_val;
          else if (cnt_q == '0)                tmo   = 1'b1;
          else                                 cnt_d = cnt_q - 1'b1;
        end
        TM_DUAL16: begin
          if (reload_on_trig_i && trig_edge_i) begin
            cnt_d = load_val;
          end else if (lo != '0) begin
            cnt_d = {hi, lo - 1'b1};
          end else if (hi != '0) begin
            cnt_d = {hi - 1'b1, lo};
            win   = 1'b1;
          end else begin
            tmo = 1'b1;
          end
        end
        TM_ACCUM: begin
          if (trig_edge_i) begin
            if (!primed_q) begin
              cnt_d    = ld_q;
              primed_d = 1'b1;
            end else if (cnt_q == '0) begin
              tmo = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        TM_CAPT: begin
          if (trig_edge_i) begin
            tmo = 1'b1;
            cap = 1'b1;
          end else if (cnt_q == '0) begin
            cnt_d = '1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
      if (tmo) begin
        if (stop_on_irq_i) run_d = 1'b0;
        else               cnt_d = load_val;
      end
    end
  end

  always_comb begin
    ld_d = ld_q;
    if (cap)          ld_d = ~cnt_q;
    else if (ld_we_i) ld_d = ld_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      primed_q <= 1'b0;
      cnt_q    <= '0;
      ld_q     <= '0;
    end else begin
      en_q     <= en_i;
      run_q    <= run_d;
      primed_q <= primed_d;
      cnt_q    <= cnt_d;
      ld_q     <= ld_d;
    end
  end

  assign count_o  = cnt_q;
  assign ld_val_o = ld_q;
  assign tmo_o    = tmo;
  assign fire_o   = tmo & (mode != TM_DUAL16);
  assign win_o    = win;
endmodule

// File: rtl/tmr_pulse_gen.sv
module tmr_pulse_gen #(
  parameter int PRE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fire_i,
  input  logic win_i,
  output logic pre_o,
  output logic trig_o
);
  localparam int EXT_W = (PRE_CYC > 1) ? PRE_CYC - 1 : 1;

  logic [EXT_W-1:0] ext_q, ext_d;
  logic             pre_q, trig_q, pre_next;

  generate
    if (EXT_W == 1) begin : g_short
      assign ext_d = fire_i;
    end else begin : g_long
      assign ext_d = {ext_q[EXT_W-2:0], fire_i};
    end
  endgenerate

  assign pre_next = fire_i | win_i | (|ext_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= '0;
      pre_q  <= 1'b0;
      trig_q <= 1'b0;
    end else if (!en_i) begin
      ext_q  <= '0;
      pre_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      ext_q  <= ext_d;
      pre_q  <= pre_next;
      trig_q <= pre_next & pre_q;
    end
  end

  assign pre_o  = pre_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= set_i | (irq_q & ~clr_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W       = 32,
  parameter int TRIG_STAGES = 1,
  parameter int PRE_CYC     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             start_on_trig_i,
  input  logic             stop_on_irq_i,
  input  logic             reload_on_trig_i,
  input  logic             trig_src_i,
  input  logic             trig_int_i,
  input  logic             trig_ext_i,
  input  logic             ld_we_i,
  input  logic [CNT_W-1:0] ld_wdata_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] ld_val_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             pre_trig_o,
  output logic             trig_o
);
  logic trig_edge_w, tmo_w, fire_w, win_w;

  tmr_trig_sel #(.STAGES(TRIG_STAGES)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (trig_src_i),
    .int_i (trig_int_i),
    .ext_i (trig_ext_i),
    .edge_o(trig_edge_w)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_i            (en_i),
    .mode_i          (mode_i),
    .start_on_trig_i (start_on_trig_i),
    .stop_on_irq_i   (stop_on_irq_i),
    .reload_on_trig_i(reload_on_trig_i),
    .trig_edge_i     (trig_edge_w),
    .ld_we_i         (ld_we_i),
    .ld_wdata_i      (ld_wdata_i),
    .count_o         (count_o),
    .ld_val_o        (ld_val_o),
    .tmo_o           (tmo_w),
    .fire_o          (fire_w),
    .win_o           (win_w)
  );

  tmr_pulse_gen #(.PRE_CYC(PRE_CYC)) u_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .fire_i(fire_w),
    .win_i (win_w),
    .pre_o (pre_trig_o),
    .trig_o(trig_o)
  );

  tmr_irq_flag u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (tmo_w),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             irq_clr_i,
  input logic             tmo_i,
  input logic             irq_i,
  input logic             pre_i,
  input logic             trig_i,
  input logic [CNT_W-1:0] count_i
);
  // R5: trigger only inside a pre-trigger pulse
  p_trig_in_pre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> pre_i);

  // R5: trigger rises only after pre-trigger was already high
  p_trig_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_i) |-> $past(pre_i));

  // R8: timeout strobe always leaves the flag set
  p_irq_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> irq_i);

  // R8: flag holds without a clear
  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !irq_clr_i) |=> irq_i);

  // R8: clear without a timeout empties the flag
  p_irq_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !tmo_i) |=> !irq_i);

  // R11: disabled channel drives no pulses
  p_quiet_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pre_i && !trig_i));

  // R11: disabled channel holds its count
  p_hold_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(count_i));
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .irq_clr_i(irq_clr_i),
  .tmo_i    (tmo_w),
  .irq_i    (irq_o),
  .pre_i    (pre_trig_o),
  .trig_i   (trig_o),
  .count_i  (count_o)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        sot = 1'b0, soi = 1'b0, rot = 1'b0, src = 1'b0;
  logic        tint = 1'b0, text = 1'b0;
  logic        ld_we = 1'b0;
  logic [31:0] ld_wd = '0;
  logic        clr = 1'b0;
  logic [31:0] ld_val, count;
  logic        irq, pre, trig;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .start_on_trig_i(sot), .stop_on_irq_i(soi), .reload_on_trig_i(rot),
    .trig_src_i(src), .trig_int_i(tint), .trig_ext_i(text),
    .ld_we_i(ld_we), .ld_wdata_i(ld_wd), .irq_clr_i(clr),
    .ld_val_o(ld_val), .count_o(count), .irq_o(irq),
    .pre_trig_o(pre), .trig_o(trig)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic s_t, input logic s_i, input logic r_t);
    mode = m; sot = s_t; soi = s_i; rot = r_t;
  endtask

  task automatic write_ld(input logic [31:0] v);
    ld_we = 1'b1; ld_wd = v;
    tick(1);
    ld_we = 1'b0;
  endtask

  task automatic clear_irq();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic pulse_int();
    tint = 1'b1; tick(2); tint = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    chk("R11 reset count", count, 32'd0);
    chk("R8 reset irq", {31'd0, irq}, 32'd0);
    chk("R5 reset pulses", {30'd0, pre, trig}, 32'd0);
    chk("R11 reset load", ld_val, 32'd0);
  endtask

  task automatic t_periodic();
    cfg(2'd0, 1'b0, 1'b0, 1'b0);
    write_ld(32'd5);
    en = 1'b1; tick(1);
    chk("R1 load", count, 32'd5);
    tick(5);
    chk("R1 at zero", count, 32'd0);
    chk("R1 no early irq", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R1 timeout irq", {31'd0, irq}, 32'd1);
    chk("R1 reload", count, 32'd5);
    chk("R6 pre first clk", {30'd0, pre, trig}, 32'd2);
    tick(1);
    chk("R5 trig lags pre", {30'd0, pre, trig}, 32'd3);
    tick(1);
    chk("R6 both low", {30'd0, pre, trig}, 32'd0);
    chk("R1 count", count, 32'd3);
    clear_irq();
    chk("R8 cleared", {31'd0, irq}, 32'd0);
    tick(2);
    chk("R1 at zero again", count, 32'd0);
    clear_irq();
    chk("R8 set wins over clear", {31'd0, irq}, 32'd1);
    en = 1'b0; tick(1);
    chk("R11 pulses forced low", {30'd0, pre, trig}, 32'd0);
    tick(2);
    chk("R11 count held", count, 32'd5);
    chk("R11 load kept", ld_val, 32'd5);
  endtask

  task automatic t_stop();
    clear_irq();
    cfg(2'd0, 1'b0, 1'b1, 1'b0);
    write_ld(32'd2);
    en = 1'b1; tick(1);
    chk("R7 load", count, 32'd2);
    tick(3);
    chk("R7 timeout", {31'd0, irq}, 32'd1);
    tick(3);
    chk("R7 frozen", count, 32'd0);
    en = 1'b0; tick(1);
    en = 1'b1; tick(1);
    chk("R7 enable restart", count, 32'd2);
    en = 1'b0; tick(1);
  endtask

  task automatic t_start_trig();
    clear_irq();
    cfg(2'd0, 1'b1, 1'b1, 1'b0);
    write_ld(32'd4);
    en = 1'b1; tick(3);
    chk("R9 idle until trigger", count, 32'd2);
    tint = 1'b1; tick(1);
    chk("R12 no effect yet", count, 32'd2);
    tick(1);
    chk("R9 start on trigger", count, 32'd4);
    tick(3);
    chk("R12 held level acts once", count, 32'd1);
    tint = 1'b0;
    tick(2);
    chk("R7 stopped irq", {31'd0, irq}, 32'd1);
    tick(2);
    chk("R7 stopped count", count, 32'd0);
    tint = 1'b1; tick(2);
    chk("R7 trigger restart", count, 32'd4);
    tint = 1'b0;
    en = 1'b0; tick(1);
  endtask

  task automatic t_reload_src();
    clear_irq();
    cfg(2'd0, 1'b0, 1'b0, 1'b1);
    write_ld(32'd10);
    en = 1'b1; tick(1);
    chk("R9 load", count, 32'd10);
    tick(4);
    tint = 1'b1; tick(1);
    chk("R12 latency", count, 32'd5);
    tick(1);
    chk("R9 reload on trigger", count, 32'd10);
    tint = 1'b0; tick(1);
    chk("R9 running", count, 32'd9);
    src = 1'b1;
    tint = 1'b1; tick(2);
    chk("R10 internal ignored", count, 32'd7);
    tint = 1'b0; text = 1'b1; tick(2);
    chk("R10 external used", count, 32'd10);
    text = 1'b0; src = 1'b0;
    en = 1'b0; tick(1);
  endtask

  task automatic t_dual();
    clear_irq();
    cfg(2'd1, 1'b0, 1'b0, 1'b0);
    write_ld(32'h0003_0002);
    en = 1'b1; tick(1);
    chk("R2 load", count, 32'h0003_0002);
    tick(2);
    chk("R2 low half done", count, 32'h0003_0000);
    chk("R2 no window yet", {31'd0, pre}, 32'd0);
    tick(1);
    chk("R2 high half steps", count, 32'h0002_0000);
    chk("R6 window opens", {30'd0, pre, trig}, 32'd2);
    tick(1);
    chk("R5 trig one clock later", {30'd0, pre, trig}, 32'd3);
    tick(1);
    chk("R6 window third clock", {30'd0, pre, trig}, 32'd3);
    chk("R2 no irq inside window", {31'd0, irq}, 32'd0);
    tick(1);
    chk("R6 both fall at timeout", {30'd0, pre, trig}, 32'd0);
    chk("R2 irq at timeout", {31'd0, irq}, 32'd1);
    chk("R2 reload", count, 32'h0003_0002);
    en = 1'b0; tick(1);
  endtask

  task automatic t_accum();
    clear_irq();
    cfg(2'd2, 1'b0, 1'b0, 1'b0);
    write_ld(32'd2);
    en = 1'b1; tick(1);
    write_ld(32'd3);
    tick(3);
    chk("R3 static without triggers", count, 32'd2);
    pulse_int();
    chk("R3 first edge loads", count, 32'd3);
    pulse_int();
    chk("R3 edge step", count, 32'd2);
    pulse_int();
    pulse_int();
    chk("R3 reached zero", count, 32'd0);
    chk("R3 no irq at zero", {31'd0, irq}, 32'd0);
    pulse_int();
    chk("R3 timeout irq", {31'd0, irq}, 32'd1);
    chk("R3 reload", count, 32'd3);
    chk("R6 second pulse clock", {30'd0, pre, trig}, 32'd3);
    en = 1'b0; tick(1);
  endtask

  task automatic t_capture();
    clear_irq();
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    en = 1'b1; tick(1);
    chk("R4 start all ones", count, 32'hFFFF_FFFF);
    tick(6);
    chk("R4 counting", count, 32'hFFFF_FFF9);
    tint = 1'b1; tick(2);
    tint = 1'b0;
    chk("R4 captured inverse", ld_val, 32'd7);
    chk("R4 irq", {31'd0, irq}, 32'd1);
    chk("R4 restart", count, 32'hFFFF_FFFF);
    chk("R6 pre first clock", {30'd0, pre, trig}, 32'd2);
    tick(1);
    chk("R5 capture trig", {30'd0, pre, trig}, 32'd3);
    en = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_periodic();
    t_stop();
    t_start_trig();
    t_reload_src();
    t_dual();
    t_accum();
    t_capture();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule